// File: doc/BRIEF.md
# Sector Buffer Program Controller

This controller sits inside a byte-wide nonvolatile memory model. The host writes bytes, and the controller gathers them into a sector buffer of 256 bytes. The first accepted write fixes the sector that the buffer belongs to. Later writes may land on any byte of that sector, in any order. Each accepted write restarts a load-window timer. When the timer runs out with no new accepted write, the controller starts a timed internal cycle on its own. That cycle erases the whole sector in the backing array and then writes the buffered bytes into it.

Bytes that were never loaded in the window end up as 0xFF. A per-byte mask output records which offsets were loaded. While the internal cycle runs, the busy output is high, host writes are dropped, and every read returns a status byte instead of array data. In the status byte, bit 7 is the complement of bit 7 of the last loaded byte, and bit 6 flips on each successive read. Once the cycle ends, reads return array contents again.

Top module: `sector_prog_ctrl`

## Requirements
- R1: While reset is held and just after it is released, busy, rvalid and arr_we are 0 and loaded_mask is all zeros.
- R2: The first write accepted while idle captures the sector from addr[17:8]. Each accepted write stores wdata at buffer offset addr[7:0], and offsets may arrive in any order.
- R3: While a window is open, a write whose addr[17:8] differs from the captured sector is ignored. Its data is not stored, its mask bit is not set, and it does not restart the timer.
- R4: busy rises exactly LOAD_WINDOW clock cycles after the last accepted write. A write to the captured sector that is accepted in the last cycle before expiry restarts the full window.
- R5: The internal cycle writes the backing array only at addresses inside the captured sector. When it ends, each loaded offset holds its last loaded byte and each unloaded offset holds 0xFF.
- R6: loaded_mask bit i is 1 exactly when offset i was loaded in the current or most recent window. The first write of a new window clears all other bits.
- R7: busy stays high for exactly PROG_CYCLES cycles, and arr_we is never high while busy is low.
- R8: rvalid is high exactly one cycle after rd_en. While busy is high, the returned byte has bit 7 equal to the inverse of bit 7 of the last loaded byte and bits 5:0 equal to that byte's bits 5:0.
- R9: On busy reads, bit 6 is 0 on the first read after busy rises and then alternates on each further busy read.
- R10: Host writes made while busy is high are dropped. They change neither the mask nor the array contents.
- R11: While busy is low, a read returns the array byte at addr, one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 18 | Host byte address (sector in 17:8, offset in 7:0) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read result or busy status byte |
| rvalid | output | 1 | rdata valid, one cycle after rd_en |
| busy | output | 1 | Internal erase-and-program cycle running |
| loaded_mask | output | 256 | Per-offset loaded flags of the latest window |
| arr_we | output | 1 | Backing array write enable |
| arr_waddr | output | 18 | Backing array write address |
| arr_wdata | output | 8 | Backing array write data |
| arr_raddr | output | 18 | Backing array read address |
| arr_rdata | input | 8 | Backing array read data (combinational) |

## Verification
The first window loads four scattered offsets out of order. A write to a foreign sector is placed in the middle of the timeout. The readback and mask then separate storing and timer restart from correct rejection. The second window puts a write in the very last cycle before expiry, so a timer that expires one cycle early or ignores the restart is exposed by when busy rises. Polls during each busy period use a last byte with bit 7 set in one window and clear in the other, which makes the inversion and the bit 6 alternation visible. A write made during busy is followed by a readback of its offset, which must read 0xFF, to show that it was dropped.

// File: rtl/spc_pkg.sv
package spc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } spc_state_e;
endpackage

// File: rtl/spc_load_timer.sv
// Counts idle cycles since the last accepted write; flags expiry.
module spc_load_timer #(
   parameter int LOAD_WINDOW = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic expire
);
   localparam int CNT_W = $clog2(LOAD_WINDOW + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LOAD_WINDOW - 1);

   generate
      if (LOAD_WINDOW < 2) begin : g_bad_window
         $error("LOAD_WINDOW must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (run && cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire = run && !restart && (cnt_q == LAST);
endmodule

// File: rtl/spc_sector_buf.sv
// Sector staging RAM plus per-offset loaded mask.
module spc_sector_buf #(
   parameter int DATA_W = 8,
   parameter int OFFS_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              first,
   input  logic [OFFS_W-1:0] woffs,
   input  logic [DATA_W-1:0] wdata,
   input  logic [OFFS_W-1:0] roffs,
   output logic [DATA_W-1:0] rdata,
   output logic              rloaded,
   output logic [(1<<OFFS_W)-1:0] mask
);
   localparam int DEPTH = 1 << OFFS_W;

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DEPTH-1:0]  mask_q;
   logic [DEPTH-1:0]  hit;

   always_comb begin
      hit = '0;
      hit[woffs] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr) begin
         mem_q[woffs] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr) begin
         mask_q <= (first ? '0 : mask_q) | hit;
      end
   end

   assign rdata   = mem_q[roffs];
   assign rloaded = mask_q[roffs];
   assign mask    = mask_q;
endmodule

// File: rtl/spc_prog_seq.sv
// Timed internal cycle: optional erase pass, then program pass.
module spc_prog_seq #(
   parameter int ADDR_W      = 18,
   parameter int DATA_W      = 8,
   parameter int OFFS_W      = 8,
   parameter int PROG_CYCLES = 600,
   parameter bit ERASE_FIRST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [ADDR_W-OFFS_W-1:0] sector,
   input  logic [DATA_W-1:0]        buf_rdata,
   input  logic                     buf_loaded,
   output logic [OFFS_W-1:0]        buf_roffs,
   output logic                     active,
   output logic                     done,
   output logic                     arr_we,
   output logic [ADDR_W-1:0]        arr_waddr,
   output logic [DATA_W-1:0]        arr_wdata
);
   localparam int SB     = 1 << OFFS_W;
   localparam int PASSES = ERASE_FIRST ? 2 : 1;
   localparam int PC_W   = $clog2(PROG_CYCLES + 1) + 1;
   localparam logic [PC_W-1:0] PC_LAST = PC_W'(PROG_CYCLES - 1);
   localparam logic [PC_W-1:0] PC_WEND = PC_W'(PASSES * SB);
   localparam logic [DATA_W-1:0] ERASED = '1;

   generate
      if (PROG_CYCLES < PASSES * SB) begin : g_bad_len
         $error("PROG_CYCLES too short for the write passes");
      end
   endgenerate

   logic [PC_W-1:0] pc_q;
   logic            act_q;
   logic [DATA_W-1:0] fill;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         pc_q  <= '0;
      end else if (start) begin
         act_q <= 1'b1;
         pc_q  <= '0;
      end else if (act_q) begin
         if (pc_q == PC_LAST) begin
            act_q <= 1'b0;
         end
         pc_q <= pc_q + 1'b1;
      end
   end

   assign fill = buf_loaded ? buf_rdata : ERASED;

   generate
      if (ERASE_FIRST) begin : g_two_pass
         assign arr_wdata = pc_q[OFFS_W] ? fill : ERASED;
      end else begin : g_one_pass
         assign arr_wdata = fill;
      end
   endgenerate

   assign buf_roffs = pc_q[OFFS_W-1:0];
   assign arr_we    = act_q && (pc_q < PC_WEND);
   assign arr_waddr = {sector, pc_q[OFFS_W-1:0]};
   assign active    = act_q;
   assign done      = act_q && (pc_q == PC_LAST);
endmodule

// File: rtl/sector_prog_ctrl.sv
module sector_prog_ctrl
   import spc_pkg::*;
#(
   parameter int ADDR_W      = 18,
   parameter int DATA_W      = 8,
   parameter int OFFS_W      = 8,
   parameter int LOAD_WINDOW = 64,
   parameter int PROG_CYCLES = 600,
   parameter bit ERASE_FIRST = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic                   rd_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      wdata,
   output logic [DATA_W-1:0]      rdata,
   output logic                   rvalid,
   output logic                   busy,
   output logic [(1<<OFFS_W)-1:0] loaded_mask,
   output logic                   arr_we,
   output logic [ADDR_W-1:0]      arr_waddr,
   output logic [DATA_W-1:0]      arr_wdata,
   output logic [ADDR_W-1:0]      arr_raddr,
   input  logic [DATA_W-1:0]      arr_rdata
);
   localparam int SECT_W = ADDR_W - OFFS_W;

   generate
      if (SECT_W < 1) begin : g_bad_addr
         $error("ADDR_W must exceed OFFS_W");
      end
      if (DATA_W < 3) begin : g_bad_data
         $error("DATA_W must be at least 3");
      end
   endgenerate

   spc_state_e        state_q;
   logic [SECT_W-1:0] sector_q;
   logic [DATA_W-1:0] last_q;
   logic              toggle_q;

   logic              sect_hit, accept, first, expire, start, done, active;
   logic [DATA_W-1:0] buf_rdata;
   logic              buf_loaded;
   logic [OFFS_W-1:0] buf_roffs;
   logic [DATA_W-1:0] status;

   assign sect_hit = (addr[ADDR_W-1:OFFS_W] == sector_q);
   assign first    = (state_q == ST_IDLE);
   assign accept   = wr_en && (first || (state_q == ST_LOAD && sect_hit));
   assign start    = expire;

   spc_load_timer #(.LOAD_WINDOW(LOAD_WINDOW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == ST_LOAD),
      .restart (accept),
      .expire  (expire)
   );

   spc_sector_buf #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (accept),
      .first   (first),
      .woffs   (addr[OFFS_W-1:0]),
      .wdata   (wdata),
      .roffs   (buf_roffs),
      .rdata   (buf_rdata),
      .rloaded (buf_loaded),
      .mask    (loaded_mask)
   );

   spc_prog_seq #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .OFFS_W      (OFFS_W),
      .PROG_CYCLES (PROG_CYCLES),
      .ERASE_FIRST (ERASE_FIRST)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .sector     (sector_q),
      .buf_rdata  (buf_rdata),
      .buf_loaded (buf_loaded),
      .buf_roffs  (buf_roffs),
      .active     (active),
      .done       (done),
      .arr_we     (arr_we),
      .arr_waddr  (arr_waddr),
      .arr_wdata  (arr_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         sector_q <= '0;
         last_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               state_q  <= ST_LOAD;
               sector_q <= addr[ADDR_W-1:OFFS_W];
            end
            ST_LOAD: if (expire) state_q <= ST_PROG;
            ST_PROG: if (done)   state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
         if (accept) last_q <= wdata;
      end
   end

   assign status = {~last_q[DATA_W-1], toggle_q, last_q[DATA_W-3:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid   <= 1'b0;
         rdata    <= '0;
         toggle_q <= 1'b0;
      end else begin
         rvalid <= rd_en;
         if (rd_en) rdata <= active ? status : arr_rdata;
         if (start) toggle_q <= 1'b0;
         else if (rd_en && active) toggle_q <= ~toggle_q;
      end
   end

   assign busy      = active;
   assign arr_raddr = addr;
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
   parameter int ADDR_W      = 18,
   parameter int OFFS_W      = 8,
   parameter int PROG_CYCLES = 600
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   wr_en,
   input logic                   rd_en,
   input logic                   rvalid,
   input logic                   busy,
   input logic                   arr_we,
   input logic [ADDR_W-1:0]      arr_waddr,
   input logic [(1<<OFFS_W)-1:0] loaded_mask
);
   localparam int BC_W = $clog2(PROG_CYCLES + 2) + 1;

   logic [BC_W-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cnt <= '0;
      else if (busy) busy_cnt <= busy_cnt + 1'b1;
      else           busy_cnt <= '0;
   end

   assert_we_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);

   assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_cnt == BC_W'(PROG_CYCLES));

   assert_one_sector_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && $past(arr_we)) |->
         arr_waddr[ADDR_W-1:OFFS_W] == $past(arr_waddr[ADDR_W-1:OFFS_W]));

   assert_rvalid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rvalid);

   assert_rvalid_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rvalid);

   assert_busy_write_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en) |=> $stable(loaded_mask));
endmodule

bind sector_prog_ctrl spc_checker #(
   .ADDR_W      (ADDR_W),
   .OFFS_W      (OFFS_W),
   .PROG_CYCLES (PROG_CYCLES)
) u_spc_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .rd_en       (rd_en),
   .rvalid      (rvalid),
   .busy        (busy),
   .arr_we      (arr_we),
   .arr_waddr   (arr_waddr),
   .loaded_mask (loaded_mask)
);

// File: tb/sector_prog_ctrl_test.sv
`timescale 1ns/1ps
module sector_prog_ctrl_test;
   localparam int LW = 24;
   localparam int PC = 560;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0, rd_en = 1'b0;
   logic [17:0]  addr = '0;
   logic [7:0]   wdata = '0;
   logic [7:0]   rdata;
   logic         rvalid, busy, arr_we;
   logic [255:0] loaded_mask;
   logic [17:0]  arr_waddr, arr_raddr;
   logic [7:0]   arr_wdata, arr_rdata;

   always #10 clk = ~clk;

   sector_prog_ctrl #(.LOAD_WINDOW(LW), .PROG_CYCLES(PC)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .busy(busy),
      .loaded_mask(loaded_mask), .arr_we(arr_we), .arr_waddr(arr_waddr),
      .arr_wdata(arr_wdata), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata)
   );

   // backing array model
   logic [7:0] mem [4096];
   initial for (int i = 0; i < 4096; i++) mem[i] = 8'(i) ^ 8'h5A;
   always @(posedge clk) if (arr_we) mem[arr_waddr[11:0]] <= arr_wdata;
   assign arr_rdata = mem[arr_raddr[11:0]];

   int n_chk = 0, n_bad = 0;
   int cyc = 0, rise_cyc = 0, fall_cyc = 0, bad_wr = 0;
   logic [9:0] exp_sect = '0;
   logic prev_busy = 1'b0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (arr_we && arr_waddr[17:8] != exp_sect) bad_wr <= bad_wr + 1;
   end

   always @(negedge clk) begin
      if (busy && !prev_busy) rise_cyc = cyc;
      if (!busy && prev_busy) fall_cyc = cyc;
      prev_busy = busy;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // scoreboard
   typedef struct { logic [7:0] v; string tag; } exp_t;
   exp_t sb_q[$];

   always @(negedge clk) begin
      if (rvalid) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R8 unexpected rvalid", 1, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(rdata == e.v, e.tag, rdata, e.v);
         end
      end
   end

   function automatic logic [7:0] poll_val(input logic [7:0] d, input logic t);
      return {~d[7], t, d[5:0]};
   endfunction

   task automatic do_write(input logic [17:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(input logic [17:0] a, input logic [7:0] e, input string tag);
      exp_t it;
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      it.v = e; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // Called just after the edge of the last accepted write.
   task automatic check_window(input bit inject, input string tag);
      for (int k = 1; k <= LW; k++) begin
         @(negedge clk);
         if (inject && k == 4) begin
            wr_en = 1'b1; addr = 18'h0_0533; wdata = 8'h6B;
         end
         if (inject && k == 5) wr_en = 1'b0;
         if (k == LW - 1) chk(busy == 1'b0, {tag, " busy early"}, busy, 0);
         if (k == LW)     chk(busy == 1'b1, {tag, " busy at window end"}, busy, 1);
      end
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 5000) begin
         @(negedge clk);
         n++;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      logic [255:0] m;
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(busy == 0 && rvalid == 0 && arr_we == 0, "R1 outputs in reset", {busy, rvalid, arr_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(loaded_mask == '0 && busy == 0, "R1 after release", int'(loaded_mask[31:0]), 0);

      // R11 idle read
      do_read(18'h0_0005, 8'h05 ^ 8'h5A, "R11 idle read");
      do_read(18'h0_02FF, 8'hFF ^ 8'h5A, "R11 idle read 2");

      // Window 1: sector 3, scattered offsets (R2), foreign write mid-timeout (R3)
      exp_sect = 10'd3;
      do_write(18'h0_0310, 8'hA7);
      do_write(18'h0_0302, 8'h3C);
      do_write(18'h0_0533, 8'h11); // foreign sector, ignored R3
      do_write(18'h0_03FF, 8'h5E);
      do_write(18'h0_0380, 8'hD2);
      check_window(1'b1, "R4 R3 window1");
      m = '0; m[8'h10] = 1; m[8'h02] = 1; m[8'hFF] = 1; m[8'h80] = 1;
      chk(loaded_mask == m, "R6 mask window1", int'(loaded_mask[63:32]), int'(m[63:32]));
      chk(loaded_mask[8'h33] == 0, "R3 foreign offset unmasked", loaded_mask[8'h33], 0);

      // busy polls R8 R9
      do_read(18'h0_0380, poll_val(8'hD2, 1'b0), "R9 R8 poll 1");
      do_read(18'h0_0000, poll_val(8'hD2, 1'b1), "R9 R8 poll 2");
      do_read(18'h0_0380, poll_val(8'hD2, 1'b0), "R9 R8 poll 3");
      // R10 write while busy
      do_write(18'h0_0344, 8'h99);
      @(negedge clk);
      chk(loaded_mask == m, "R10 mask unchanged", int'(loaded_mask[95:64]), int'(m[95:64]));
      wait_idle();
      chk(fall_cyc - rise_cyc == PC, "R7 busy length", fall_cyc - rise_cyc, PC);

      // readback R5 R2 R10 R3
      do_read(18'h0_0380, 8'hD2, "R8 true data after cycle");
      do_read(18'h0_0310, 8'hA7, "R2 R5 offset 10");
      do_read(18'h0_0302, 8'h3C, "R2 R5 offset 02");
      do_read(18'h0_03FF, 8'h5E, "R2 R5 offset FF");
      do_read(18'h0_0344, 8'hFF, "R10 R5 dropped write reads erased");
      do_read(18'h0_0300, 8'hFF, "R5 unloaded offset 00");
      do_read(18'h0_02FF, 8'hFF ^ 8'h5A, "R5 neighbour sector untouched");
      do_read(18'h0_0533, 8'h33 ^ 8'h5A, "R3 foreign byte not written");

      // Window 2: sector 4, write in the last cycle before expiry (R4)
      exp_sect = 10'd4;
      do_write(18'h0_0401, 8'hC3);
      m = '0; m[8'h01] = 1;
      chk(loaded_mask == m, "R6 mask cleared by new window", int'(loaded_mask[31:0]), int'(m[31:0]));
      repeat (LW - 2) @(negedge clk);
      do_write(18'h0_047E, 8'h35);
      chk(busy == 1'b0, "R4 restart at last cycle", busy, 0);
      check_window(1'b0, "R4 window2");
      do_read(18'h0_0401, poll_val(8'h35, 1'b0), "R8 R9 poll inverted bit7");
      do_read(18'h0_0401, poll_val(8'h35, 1'b1), "R9 poll toggle");
      wait_idle();
      do_read(18'h0_0401, 8'hC3, "R5 window2 byte 01");
      do_read(18'h0_047E, 8'h35, "R5 window2 byte 7E");
      do_read(18'h0_0402, 8'hFF, "R5 window2 unloaded");
      do_read(18'h0_03FF, 8'h5E, "R5 earlier sector kept");
      repeat (3) @(negedge clk);
      chk(bad_wr == 0, "R5 writes confined to sector", bad_wr, 0);
      chk(sb_q.size() == 0, "R8 all reads answered", sb_q.size(), 0);
      finish_run();
   end
endmodule